// File: doc/BRIEF.md
# Shared-Timer Input Debounce Filter

This block cleans up a bank of raw input pins before the rest of the chip sees them. Each raw pin first passes through a multi-stage synchronizer. A filter then drives the pin's output, and that output only takes a new level once the synchronized input has held that level for a programmed number of clock cycles. The bank has three period timers that every pin shares. Each pin picks one of the three timers, or no filtering at all, through a 2-bit selector.

The selector is stored as two bit-planes, one high plane and one low plane. Bit n of each plane belongs to pin n. Software writes the planes and the three period values through a simple write/read register port. Converting time units to cycles and deciding which pin uses which timer are left to software. The register port has no notion of pin ownership, so debounce settings can always be written.

Each pin runs a two-state machine. In ST_IDLE the filtered output agrees with the synchronized input and the pin counter is zero. In ST_WAIT the two disagree and the counter is running. The transitions are:
- IDLE to WAIT when a disagreement appears.
- WAIT to IDLE on acceptance, when the counter reaches the period.
- WAIT to IDLE on retraction, when the input returns to the output level.
- WAIT to WAIT on a configuration restart, with the counter cleared.
- Any state to IDLE under bypass.

Top module: `dbf_bank`

## Requirements
- R1: After reset, every selector bit and every period reads back 0, and every filtered output is 0. With everything at zero, each output follows its synchronized input.
- R2: The register index map is fixed. Index 0 holds the high selector plane, index 1 the low selector plane, and indices 2, 3 and 4 hold the periods of timers 1, 2 and 3. A read returns the value last written. Indices 5 to 7 read as 0, and writes to them change nothing.
- R3: The selector of pin n is {high plane bit n, low plane bit n}. Value 0 means bypass: a raw change appears on the output 3 cycles later (2 synchronizer stages plus 1 output register).
- R4: Selector values 1 to 3 use the period P of that timer. When P is nonzero, a raw change held steadily appears on the output 2+P cycles later.
- R5: A synchronized pulse shorter than P cycles never reaches the output. The counter starts again from zero on the next disagreement.
- R6: A selected timer whose period is 0 behaves exactly like bypass.
- R7: Writing a timer period clears the counter of every pin currently selecting that timer. Writing a selector plane clears the counter of every pin whose selector bit changes. The clearing happens in the write cycle, and no output change is accepted in that cycle.
- R8: Pins that select different timers filter independently with their own periods, and pins that share a timer keep independent counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| pin_raw | input | 32 | Raw, asynchronous input pins |
| pin_filt | output | 32 | Filtered input pins |

## Verification
A single-pin step under bypass and under a nonzero period gives the exact latency of each path, which separates the synchronizer depth from the counter's off-by-one. A short glitch checks that sub-period pulses are suppressed and that the counter is cleared. A mid-count rewrite of an unchanged period checks restart-on-write rather than compare-on-change. A zero period on a selected timer checks that it falls back to bypass. Pseudo-random traffic on all 32 pins, with mixed timer choices, is compared every cycle with the behavioural model, so crosstalk between pins or timers is caught.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } pin_state_e;

    localparam int unsigned NTIMERS      = 3;
    localparam int unsigned IDX_SEL_HI   = 0;
    localparam int unsigned IDX_SEL_LO   = 1;
    localparam int unsigned IDX_PER_BASE = 2;
endpackage

// File: rtl/dbf_sync.sv
module dbf_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d_in;
            for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign d_out = stg_q[STAGES-1];
endmodule

// File: rtl/dbf_regs.sv
module dbf_regs
    import dbf_pkg::*;
#(
    parameter int unsigned NPINS = 32,
    parameter int unsigned PER_W = 32,
    parameter int unsigned DW    = 32,
    parameter int unsigned AW    = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [AW-1:0]              addr,
    input  logic [DW-1:0]              wdata,
    output logic [DW-1:0]              rdata,
    output logic [NPINS-1:0]           sel_hi,
    output logic [NPINS-1:0]           sel_lo,
    output logic [NTIMERS*PER_W-1:0]   per_flat,
    output logic [NPINS-1:0]           restart
);
    logic [PER_W-1:0] per_q [NTIMERS];
    logic [NPINS-1:0] hi_q, lo_q;
    logic             wr_hi, wr_lo;

    assign wr_hi = we && (addr == AW'(IDX_SEL_HI));
    assign wr_lo = we && (addr == AW'(IDX_SEL_LO));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
            for (int t = 0; t < int'(NTIMERS); t++) per_q[t] <= '0;
        end else begin
            if (wr_hi) hi_q <= wdata[NPINS-1:0];
            if (wr_lo) lo_q <= wdata[NPINS-1:0];
            for (int t = 0; t < int'(NTIMERS); t++) begin
                if (we && (addr == AW'(int'(IDX_PER_BASE) + t)))
                    per_q[t] <= wdata[PER_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(IDX_SEL_HI)) rdata = DW'(hi_q);
        if (addr == AW'(IDX_SEL_LO)) rdata = DW'(lo_q);
        for (int t = 0; t < int'(NTIMERS); t++) begin
            if (addr == AW'(int'(IDX_PER_BASE) + t)) rdata = DW'(per_q[t]);
        end
    end

    // Per-pin restart: selector bit changes, or the pin's own timer rewritten.
    always_comb begin
        for (int p = 0; p < int'(NPINS); p++) begin
            logic [1:0] s;
            s = {hi_q[p], lo_q[p]};
            restart[p] = (wr_hi && (wdata[p] != hi_q[p])) ||
                         (wr_lo && (wdata[p] != lo_q[p])) ||
                         (we && (s != 2'd0) &&
                          (addr == AW'(int'(IDX_PER_BASE) + int'(s) - 1)));
        end
    end

    genvar g;
    generate
        for (g = 0; g < int'(NTIMERS); g++) begin : g_flat
            assign per_flat[g*PER_W +: PER_W] = per_q[g];
        end
    endgenerate

    assign sel_hi = hi_q;
    assign sel_lo = lo_q;

    AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (addr > AW'(int'(IDX_PER_BASE) + int'(NTIMERS) - 1)))
        |=> ($stable(hi_q) && $stable(lo_q) && $stable(per_flat))); // R2
    AST_SEL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (sel_hi == $past(wdata[NPINS-1:0]))); // R2
endmodule

// File: rtl/dbf_pin.sv
module dbf_pin
    import dbf_pkg::*;
#(
    parameter int unsigned PER_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     s_in,
    input  logic [1:0]               sel,
    input  logic [NTIMERS*PER_W-1:0] per_flat,
    input  logic                     restart,
    output logic                     filt_out
);
    pin_state_e       st_q, st_n;
    logic [PER_W-1:0] cnt_q;
    logic [PER_W-1:0] per_sel;
    logic             bypass, differ, done;

    always_comb begin
        per_sel = '0;
        if (sel != 2'd0) per_sel = per_flat[(int'(sel) - 1) * int'(PER_W) +: PER_W];
    end

    assign bypass = (per_sel == '0);
    assign differ = (s_in != filt_out);
    assign done   = ({1'b0, cnt_q} + 1'b1) >= {1'b0, per_sel};

    // Next-state logic
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (!bypass && differ) st_n = ST_WAIT;
            end
            ST_WAIT: begin
                if (bypass)              st_n = ST_IDLE;
                else if (restart)        st_n = differ ? ST_WAIT : ST_IDLE;
                else if (!differ)        st_n = ST_IDLE;
                else if (done)           st_n = ST_IDLE;
                else                     st_n = ST_WAIT;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_n;
    end

    // Output and counter register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_out <= 1'b0;
            cnt_q    <= '0;
        end else if (bypass) begin
            filt_out <= s_in;
            cnt_q    <= '0;
        end else if (restart || !differ) begin
            cnt_q    <= '0;
        end else if (done) begin
            filt_out <= s_in;
            cnt_q    <= '0;
        end else begin
            cnt_q    <= cnt_q + 1'b1;
        end
    end

    AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> (cnt_q == '0)); // R4
    AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        !bypass |-> (cnt_q < per_sel)); // R5
    AST_CHANGE_AFTER_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        ((filt_out != $past(filt_out)) && !$past(bypass) && !$past(restart))
        |-> (({1'b0, $past(cnt_q)} + 1'b1) >= {1'b0, $past(per_sel)})); // R4
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !bypass) |=> ((cnt_q == '0) && $stable(filt_out))); // R7
endmodule

// File: rtl/dbf_bank.sv
module dbf_bank
    import dbf_pkg::*;
#(
    parameter int unsigned NPINS       = 32,
    parameter int unsigned PER_W       = 32,
    parameter int unsigned DW          = 32,
    parameter int unsigned AW          = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [DW-1:0]    cfg_wdata,
    output logic [DW-1:0]    cfg_rdata,
    input  logic [NPINS-1:0] pin_raw,
    output logic [NPINS-1:0] pin_filt
);
    logic [NPINS-1:0]         s_bus, sel_hi, sel_lo, restart;
    logic [NTIMERS*PER_W-1:0] per_flat;

    dbf_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_raw),
        .d_out (s_bus)
    );

    dbf_regs #(.NPINS(NPINS), .PER_W(PER_W), .DW(DW), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .sel_hi   (sel_hi),
        .sel_lo   (sel_lo),
        .per_flat (per_flat),
        .restart  (restart)
    );

    genvar p;
    generate
        for (p = 0; p < int'(NPINS); p++) begin : g_pin
            dbf_pin #(.PER_W(PER_W)) u_pin (
                .clk      (clk),
                .rst_n    (rst_n),
                .s_in     (s_bus[p]),
                .sel      ({sel_hi[p], sel_lo[p]}),
                .per_flat (per_flat),
                .restart  (restart[p]),
                .filt_out (pin_filt[p])
            );
        end
    endgenerate
endmodule

// File: tb/dbf_bank_tb.sv
`timescale 1ns/1ps
module dbf_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] pin_raw = '0;
    logic [31:0] pin_filt;

    int    n_checks = 0, n_fail = 0, cyc = 0;
    string cur_req = "R1";

    dbf_bank dut_i (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
                    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
                    .pin_raw(pin_raw), .pin_filt(pin_filt));

    always #2.5 clk = ~clk;

    // Behavioural reference model
    logic [31:0] m_hi, m_lo, m_s1, m_s2, m_out;
    longint      m_per [4];
    longint      m_cnt [32];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hi = 0; m_lo = 0; m_s1 = 0; m_s2 = 0; m_out = 0;
            foreach (m_per[i]) m_per[i] = 0;
            foreach (m_cnt[i]) m_cnt[i] = 0;
        end else begin
            for (int p = 0; p < 32; p++) begin
                int sel; longint per; bit rs;
                sel = {m_hi[p], m_lo[p]};
                per = (sel == 0) ? 0 : m_per[sel];
                rs = cfg_we && ((cfg_addr == 0 && cfg_wdata[p] != m_hi[p]) ||
                                (cfg_addr == 1 && cfg_wdata[p] != m_lo[p]) ||
                                (sel != 0 && int'(cfg_addr) == sel + 1));
                if (per == 0) begin m_out[p] = m_s2[p]; m_cnt[p] = 0; end
                else if (rs || m_s2[p] == m_out[p]) m_cnt[p] = 0;
                else if (m_cnt[p] + 1 >= per) begin m_out[p] = m_s2[p]; m_cnt[p] = 0; end
                else m_cnt[p] = m_cnt[p] + 1;
            end
            m_s2 = m_s1; m_s1 = pin_raw;
            if (cfg_we) begin
                if (cfg_addr == 0) m_hi = cfg_wdata;
                else if (cfg_addr == 1) m_lo = cfg_wdata;
                else if (cfg_addr >= 2 && cfg_addr <= 4) m_per[cfg_addr - 1] = longint'(cfg_wdata);
            end
        end
    end

    function automatic longint m_read(int a);
        if (a == 0) return longint'(m_hi);
        if (a == 1) return longint'(m_lo);
        if (a >= 2 && a <= 4) return m_per[a-1];
        return 0;
    endfunction

    task automatic check(string req, longint act, longint exp, string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        cyc++;
        if (rst_n) check(cur_req, longint'(pin_filt), longint'(m_out), "pin_filt vs model");
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected<150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk); cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = d;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic rd_check(string req, int a);
        cfg_addr = 3'(a); #0.5;
        check(req, longint'(cfg_rdata), m_read(a), $sformatf("readback idx %0d", a));
    endtask

    // Toggle one pin and count negedges until its output follows
    task automatic latency(string req, int pin, int exp);
        int n = 0; logic old;
        @(negedge clk); old = pin_filt[pin]; pin_raw[pin] = ~pin_raw[pin];
        do begin @(negedge clk); n++; end while (pin_filt[pin] == old && n < 200);
        check(req, n, exp, $sformatf("latency pin %0d", pin));
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] lfsr;
        idle(3); rst_n = 1; @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 5; a++) begin cfg_addr = 3'(a); #0.5; check("R1", longint'(cfg_rdata), 0, "reset reg"); end
        check("R1", longint'(pin_filt), 0, "reset outputs");

        // R2: register map and unmapped indices
        cur_req = "R2";
        wr(0, 32'hA5A5_0F0F); wr(1, 32'h1234_5678); wr(2, 32'd77); wr(3, 32'd9); wr(4, 32'hFFFF_FFFF);
        for (int a = 0; a < 8; a++) rd_check("R2", a);
        wr(5, 32'hDEAD_BEEF); wr(7, 32'h1);
        for (int a = 0; a < 8; a++) rd_check("R2", a);
        wr(0, 0); wr(1, 0); wr(2, 0); wr(3, 0); wr(4, 0);
        idle(5);

        // R3: bypass latency
        cur_req = "R3";
        latency("R3", 0, 3); latency("R3", 31, 3);
        @(negedge clk); pin_raw = 32'h5555_AAAA; idle(6);
        pin_raw = 32'h0; idle(6);

        // R4: timer 1 period 5 on pins 0..7 (selector 01)
        cur_req = "R4";
        wr(2, 5); wr(1, 32'h0000_00FF); idle(4);
        latency("R4", 0, 7); latency("R4", 3, 7);

        // R5: glitch of 3 cycles is suppressed
        cur_req = "R5";
        @(negedge clk); pin_raw[1] = 1; idle(3); pin_raw[1] = 0; idle(12);
        check("R5", pin_filt[1], 0, "glitch suppressed");

        // R6: timer 2 period 0 on pins 8..15 (selector 10)
        cur_req = "R6";
        wr(3, 0); wr(0, 32'h0000_FF00); idle(4);
        latency("R6", 8, 3);

        // R7: timer 3 period 20 on pins 16..23 (selector 11); rewrite mid-count
        cur_req = "R7";
        wr(4, 20); wr(0, 32'h00FF_FF00); wr(1, 32'h00FF_00FF); idle(4);
        @(negedge clk); pin_raw[16] = 1; idle(10);
        wr(4, 20); idle(12);
        check("R7", pin_filt[16], 0, "restart delays acceptance");
        idle(12);
        check("R7", pin_filt[16], 1, "accepted after restart");

        // R8: mixed timers under pseudo-random traffic
        cur_req = "R8";
        wr(2, 3); wr(3, 7); wr(4, 2);
        wr(0, 32'hF0F0_3C3C); wr(1, 32'hCCCC_5A5A);
        lfsr = 32'h1ACE_B00C;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (lfsr[3:0] < 4'd5) pin_raw = pin_raw ^ (lfsr & {lfsr[15:0], lfsr[31:16]});
            if (i == 1500) wr(3, 4);
            if (i == 2200) wr(1, 32'h3333_A5A5);
        end
        idle(20);
        check("R8", longint'(pin_filt), longint'(m_out), "final state");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule